// File: doc/BRIEF.md
# Sliced ALU with Registered Condition Codes

This block is a 32-bit arithmetic and logic unit assembled from identical one-bit slices that pass a ripple carry from bit 0 upward. Every slice computes the same operation on its own bit of the two operands. The chain yields a combinational result and the carry out of every bit position. From these, the block derives four condition codes: negative, zero, carry and overflow. Overflow is taken from the carries out of the two most significant slices.

The condition codes are held in a flag register that loads on the rising clock edge. A hold input lets the current operation leave all four codes untouched while its result is still produced. This lets a sequencer run bookkeeping arithmetic between a compare and the branch that tests it. There is no subtract operation. To subtract, the caller drives the inverted second operand and a carry-in of one. The carry flag then reads as "no borrow".

The data path is purely combinational. No stream handshake is used: a result is valid in the same cycle as its operands, and the flags follow one edge later.

Top module: `sliced_alu`

## Requirements
- R1: With op_sel = 2'b11 (add), result equals (opnd_a + opnd_b + carry_in) modulo 2^32 in the same cycle.
- R2: op_sel selects the bitwise function: 2'b00 gives opnd_a AND opnd_b, 2'b01 gives opnd_a OR opnd_b, and 2'b10 gives NOT opnd_b.
- R3: After an unheld add, flag_v equals the carry out of bit 31 XOR the carry out of bit 30. This is equivalent to the sum's sign differing from the common sign of two like-signed operands.
- R4: After an unheld add, flag_c equals bit 32 of the unsigned sum opnd_a + opnd_b + carry_in.
- R5: After any unheld operation, flag_n equals bit 31 of that operation's result, and flag_z is 1 exactly when all 32 result bits are 0.
- R6: When hold_flags is 1 at a rising edge, all four flags keep their previous values, while result still reflects the current operands and op_sel.
- R7: After an unheld bitwise operation (op_sel other than 2'b11), flag_c and flag_v are 0.
- R8: While rst_n is 0, all four flags are 0.
- R9: A subtraction performed as add with opnd_b = ~x and carry_in = 1 yields opnd_a - x, with flag_c = 1 exactly when opnd_a >= x unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_sel | input | 2 | Operation: 00 AND, 01 OR, 10 NOT B, 11 add |
| carry_in | input | 1 | Carry into slice 0 |
| hold_flags | input | 1 | 1 = leave all four flags unchanged this cycle |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The bench targets the boundary sums. 0x7FFFFFFF + 1 must raise overflow without carry. 0xFFFFFFFF + 1 must raise carry and zero without overflow. A design that took V from the wrong pair of carries, or confused C with V, fails one of these two sums. Subtractions with equal operands, and with the first operand smaller, expose an inverted borrow sense. Stray carry-ins expose a carry that does not enter slice 0. Held cycles follow flag-changing operations, so a flag register that loads even one code during a hold is caught. Bitwise operations follow carrying adds, so stale C or V bits left after a logic operation are caught.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_NOTB = 2'b10,
    OP_ADD  = 2'b11
  } alu_op_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_codes_t;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    c_in,
  input  alu_op_t op,
  output logic    y_bit,
  output logic    c_out
);

  logic half_sum;

  always_comb begin
    half_sum = a_bit ^ b_bit;
    c_out    = (a_bit & b_bit) | (c_in & half_sum);
    unique case (op)
      OP_AND:  y_bit = a_bit & b_bit;
      OP_OR:   y_bit = a_bit | b_bit;
      OP_NOTB: y_bit = ~b_bit;
      default: y_bit = half_sum ^ c_in;
    endcase
  end

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  alu_op_t          op,
  output logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] couts
);

  logic [WIDTH:0] ripple;

  assign ripple[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit (a[i]),
      .b_bit (b[i]),
      .c_in  (ripple[i]),
      .op    (op),
      .y_bit (y[i]),
      .c_out (ripple[i+1])
    );
  end

  assign couts = ripple[WIDTH:1];

endmodule

// File: rtl/alu_flag_logic.sv
module alu_flag_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] y,
  input  logic             cout_top,
  input  logic             cout_below_top,
  input  logic             is_arith,
  output cond_codes_t      codes
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    codes.n = y[MSB];
    codes.z = (y == '0);
    codes.c = is_arith & cout_top;
    codes.v = is_arith & (cout_top ^ cout_below_top);
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold,
  input  cond_codes_t next_codes,
  output cond_codes_t codes
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      codes <= '0;
    else if (!hold)
      codes <= next_codes;
  end

  // R6: a held cycle leaves every code untouched
  p_hold_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(codes));

  // R8: reset leaves all codes cleared
  p_reset_clears_flags_r8: assert property (@(posedge clk)
    !rst_n |=> (codes == '0));

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [1:0]  op_sel,
  input  logic        carry_in,
  input  logic        hold_flags,
  output logic [31:0] result,
  output logic        flag_n,
  output logic        flag_z,
  output logic        flag_c,
  output logic        flag_v
);

  localparam int MSB = WIDTH - 1;

  alu_op_t          op;
  logic [WIDTH-1:0] couts;
  cond_codes_t      next_codes;
  cond_codes_t      codes;

  assign op = alu_op_t'(op_sel);

  alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
    .a     (opnd_a),
    .b     (opnd_b),
    .cin   (carry_in),
    .op    (op),
    .y     (result),
    .couts (couts)
  );

  alu_flag_logic #(.WIDTH(WIDTH)) u_flags (
    .y              (result),
    .cout_top       (couts[MSB]),
    .cout_below_top (couts[MSB-1]),
    .is_arith       (op == OP_ADD),
    .codes          (next_codes)
  );

  alu_flag_reg u_freg (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold_flags),
    .next_codes (next_codes),
    .codes      (codes)
  );

  assign flag_n = codes.n;
  assign flag_z = codes.z;
  assign flag_c = codes.c;
  assign flag_v = codes.v;

  // R5: zero and negative follow the result of the last unheld operation
  p_zero_tracks_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_flags |=> (flag_z == ($past(result) == '0)));
  p_neg_tracks_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_flags |=> (flag_n == $past(result[MSB])));

  // R7: bitwise operations clear carry and overflow
  p_logic_clears_cv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_flags && op != OP_ADD) |=> (!flag_c && !flag_v));

  // R3: operands of unlike sign never overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_flags && op == OP_ADD && (opnd_a[MSB] != opnd_b[MSB])) |=> !flag_v);

  // R4: carry equals bit 32 of a wide unsigned sum
  p_carry_bit32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_flags && op == OP_ADD) |=>
      (flag_c == $past((({1'b0, opnd_a} + {1'b0, opnd_b} + {32'd0, carry_in}) >> 32) != 33'd0)));

endmodule

// File: tb/sliced_alu_bench.sv
module sliced_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [1:0]  op_sel = 2'b00;
  logic        carry_in = 1'b0;
  logic        hold_flags = 1'b0;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int failures = 0;
  logic [3:0] model_nzcv = 4'b0000;

  always #5 clk = ~clk;

  sliced_alu u_sliced_alu (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_sel(op_sel), .carry_in(carry_in), .hold_flags(hold_flags),
    .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] ref_result(input logic [31:0] a, input logic [31:0] b,
                                             input logic [1:0] op, input logic ci);
    longint unsigned s;
    s = longint'(a) + longint'(b) + longint'(ci);
    case (op)
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   return ~b;
      default: return s[31:0];
    endcase
  endfunction

  // drive one operation, check result (R1/R2) then flags after the edge
  task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                      input logic ci, input logic hold, input string tag);
    logic [31:0] y;
    longint unsigned s;
    logic c, v;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = op; carry_in = ci; hold_flags = hold;
    #1;
    y = ref_result(a, b, op, ci);
    check({tag, (op == 2'b11) ? " R1 result" : " R2 result"}, result, y);
    s = longint'(a) + longint'(b) + longint'(ci);
    c = (op == 2'b11) ? s[32] : 1'b0;
    v = (op == 2'b11) ? ((a[31] == b[31]) && (y[31] != a[31])) : 1'b0;
    @(posedge clk);
    if (!hold) model_nzcv = {y[31], (y == 32'd0), c, v};
    #2;
    check({tag, hold ? " R6 flags" : (op == 2'b11 ? " R3 R4 R5 flags" : " R5 R7 flags")},
          {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, model_nzcv});
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: signed overflow, no carry
    step(32'h7FFF_FFFF, 32'h0000_0001, 2'b11, 1'b0, 1'b0, "R3 0x7FFFFFFF+1");
    // R4: unsigned carry, zero result, no overflow
    step(32'hFFFF_FFFF, 32'h0000_0001, 2'b11, 1'b0, 1'b0, "R4 0xFFFFFFFF+1");
    // R6: held ops keep previous flags while result changes
    step(32'h8000_0000, 32'h8000_0000, 2'b11, 1'b0, 1'b1, "R6 hold add");
    step(32'h0000_0000, 32'h0000_0000, 2'b10, 1'b0, 1'b1, "R6 hold notb");
    // R3: negative overflow with carry
    step(32'h8000_0000, 32'h8000_0000, 2'b11, 1'b0, 1'b0, "R3 min+min");
    // R7: logic op after carry/overflow clears C and V
    step(32'hF0F0_F0F0, 32'hFF00_FF00, 2'b00, 1'b1, 1'b0, "R7 and");
    step(32'h0000_0000, 32'h0000_0000, 2'b01, 1'b0, 1'b0, "R5 or zero");
    step(32'h1234_5678, 32'h0000_0000, 2'b10, 1'b0, 1'b0, "R2 notb");
    // R1: carry_in enters slice 0
    step(32'h0000_00FF, 32'h0000_0000, 2'b11, 1'b1, 1'b0, "R1 cin");
    // R9: subtraction as A + ~B + 1
    step(32'd5, ~32'd3, 2'b11, 1'b1, 1'b0, "R9 5-3");
    check("R9 5-3 no borrow", {31'd0, flag_c}, 32'd1);
    step(32'd3, ~32'd5, 2'b11, 1'b1, 1'b0, "R9 3-5");
    check("R9 3-5 borrow", {31'd0, flag_c}, 32'd0);
    step(32'd7, ~32'd7, 2'b11, 1'b1, 1'b0, "R9 7-7");
    check("R9 7-7 zero", {30'd0, flag_z, flag_c}, 32'd3);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 7 == 0) a = 32'h7FFF_FFFF;
      if (i % 11 == 0) b = 32'hFFFF_FFFF;
      step(a, b, 2'($urandom()), 1'($urandom()), ($urandom() % 4) == 0, "R1 R2 R5 R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule